// File: doc/BRIEF.md
# GPIO Pin Control Register Bank

This block holds the software-visible control state for one GPIO port of up to 32 pins. It keeps two per-pin registers. The first is a function-enable mask, which the pad logic combines with other settings to choose between plain digital I/O and alternate modes. The second is a driver-enable mask: a 1 makes the pin an output with its driver on, and a 0 leaves it as an input with the driver off. The block drives both masks straight to the pad logic.

Software reaches both registers through a simple synchronous bus with an address, write data, a write strobe, a read strobe and read data. Each register has a direct address, where a write replaces every bit. It also has two alias addresses, one that sets bits and one that clears them. On an alias, every 1 in the write data acts on the matching bit, and every 0 leaves its bit alone. Software can therefore change single pins without a read-modify-write sequence, and so cannot race with other code that changes other pins.

Out of reset the two masks take opposite values: the function-enable mask is all ones and the driver-enable mask is all zeros. Every pin therefore starts as an input.

Top module: `gpio_ctrl_bank`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the bank resets. After that edge `fn_en_o` is all ones, `drv_en_o` is all zeros and `bus_rdata` is zero.
- R2: A write to address 0x00 replaces the whole of `fn_en_o` with the write data, from the clock edge that samples the strobe.
- R3: A write to address 0x04 sets to 1 each `fn_en_o` bit whose write-data bit is 1. Bits written as 0 keep their value.
- R4: A write to address 0x08 clears to 0 each `fn_en_o` bit whose write-data bit is 1. Bits written as 0 keep their value.
- R5: A write to address 0x0C replaces the whole of `drv_en_o`. A `drv_en_o` bit of 1 marks its pin as a driven output, and 0 marks it as an input.
- R6: Writes to 0x10 set `drv_en_o` bits, and writes to 0x14 clear them, with the same write-one rule as R3 and R4.
- R7: A read of 0x00 returns the function-enable mask, and a read of 0x0C returns the driver-enable mask. A read of any of the four alias addresses (0x04, 0x08, 0x10, 0x14) returns zero.
- R8: Read data is registered. It appears in the cycle after the read strobe, holds the register value from before any write in that same cycle, and is zero in any cycle that follows a cycle with no read strobe.
- R9: A write to any address other than the six listed above changes neither mask, and a read of such an address returns zero. Addresses that are not multiples of four count as unlisted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte address of the access |
| bus_wdata | input | PIN_W (32) | Write data, one bit per pin |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | PIN_W (32) | Registered read data |
| fn_en_o | output | PIN_W (32) | Per-pin function-enable mask to the pads |
| drv_en_o | output | PIN_W (32) | Per-pin driver-enable mask to the pads; 1 means output |

## Verification
The bench sweeps every address from 0x00 to 0x3F, including the misaligned ones, and writes a pattern that changes with the address. The sweep separates the six decoded addresses from unlisted ones, and separates each direct address from its aliases, because only a correct decode produces the expected mask after every write. A walking-one pass then sets and clears each pin singly through the aliases of both registers, on a background of mixed ones and zeros. This pass shows whether an alias touches exactly its own bit or disturbs its neighbours. A read issued together with a write to the same register separates a read of the old value from a read of the new one.

// File: rtl/gpio_bank_pkg.sv
// Package: shared address map and decoded-access type for the GPIO control bank.
// Assumes word-aligned byte offsets; any other address is unlisted.
package gpio_bank_pkg;

    // Number of control registers held by the bank.
    localparam int NUM_REGS = 2;

    // Register indices.
    localparam int IDX_FN  = 0;
    localparam int IDX_DRV = 1;

    // Byte offsets of the direct, set-alias and clear-alias addresses.
    localparam int OFF_FN_DIR  = 'h00;
    localparam int OFF_FN_SET  = 'h04;
    localparam int OFF_FN_CLR  = 'h08;
    localparam int OFF_DRV_DIR = 'h0C;
    localparam int OFF_DRV_SET = 'h10;
    localparam int OFF_DRV_CLR = 'h14;

    // Reset value per register: 1 means all ones, 0 means all zeros.
    localparam logic [NUM_REGS-1:0] RST_ALL_ONES = 2'b01;

    // Decoded access for one cycle, one bit per register in each field.
    typedef struct packed {
        logic [NUM_REGS-1:0] wr_dir;
        logic [NUM_REGS-1:0] wr_set;
        logic [NUM_REGS-1:0] wr_clr;
        logic [NUM_REGS-1:0] rd_dir;
    } bank_access_t;

endpackage

// File: rtl/gpio_bank_decode.sv
// Module: gpio_bank_decode
// Turns the bus address and strobes into per-register direct, set, clear
// and read selects. Assumes the strobes last one cycle; an unlisted address
// raises no select, so the access is dropped.
module gpio_bank_decode
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output bank_access_t      acc
);

    localparam int STRIDE = 12;

    // Address comparison for each register's three addresses.
    always_comb begin
        acc = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (addr == ADDR_W'(OFF_FN_DIR + r * STRIDE)) begin
                acc.wr_dir[r] = wr;
                acc.rd_dir[r] = rd;
            end
            if (addr == ADDR_W'(OFF_FN_SET + r * STRIDE)) begin
                acc.wr_set[r] = wr;
            end
            if (addr == ADDR_W'(OFF_FN_CLR + r * STRIDE)) begin
                acc.wr_clr[r] = wr;
            end
        end
    end

endmodule

// File: rtl/gpio_bank_reg.sv
// Module: gpio_bank_reg
// One per-pin control register with direct, write-one-to-set and
// write-one-to-clear updates. Assumes the decoder raises at most one of the
// three write selects in a cycle; if it raises more, the direct write wins.
module gpio_bank_reg #(
    parameter int   WIDTH    = 32,
    parameter logic RST_ONES = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_dir,
    input  logic             wr_set,
    input  logic             wr_clr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);

    localparam logic [WIDTH-1:0] RST_VAL = RST_ONES ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

    // Register update: reset, replace, set bits or clear bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (wr_dir) begin
            q <= wdata;
        end else if (wr_set) begin
            q <= q | wdata;
        end else if (wr_clr) begin
            q <= q & ~wdata;
        end
    end

endmodule

// File: rtl/gpio_bank_rdata.sv
// Module: gpio_bank_rdata
// Registered read-data path. It captures the selected register's value
// from before this cycle's write. Any cycle with no read strobe, or with no
// read select, loads zero.
module gpio_bank_rdata
    import gpio_bank_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rd,
    input  logic [NUM_REGS-1:0]             rd_sel,
    input  logic [NUM_REGS-1:0][WIDTH-1:0]  regs,
    output logic [WIDTH-1:0]                rdata
);

    logic [WIDTH-1:0] mux_val;

    // OR the register values together under their one-hot read selects.
    always_comb begin
        mux_val = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            mux_val = mux_val | (regs[r] & {WIDTH{rd_sel[r]}});
        end
    end

    // Capture the read result, or zero when there is no read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd) begin
            rdata <= mux_val;
        end else begin
            rdata <= '0;
        end
    end

endmodule

// File: rtl/gpio_ctrl_bank.sv
// Module: gpio_ctrl_bank (top)
// GPIO control bank: a function-enable mask and a driver-enable mask, each
// with direct, set-alias and clear-alias addresses, on a simple synchronous
// bus. Assumes single-cycle strobes and a synchronous active-low reset.
module gpio_ctrl_bank
    import gpio_bank_pkg::*;
#(
    parameter int PIN_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PIN_W-1:0]  bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [PIN_W-1:0]  bus_rdata,
    output logic [PIN_W-1:0]  fn_en_o,
    output logic [PIN_W-1:0]  drv_en_o
);

    bank_access_t                    acc;
    logic [NUM_REGS-1:0][PIN_W-1:0]  regs;

    gpio_bank_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .addr (bus_addr),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .acc  (acc)
    );

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        gpio_bank_reg #(
            .WIDTH    (PIN_W),
            .RST_ONES (RST_ALL_ONES[r])
        ) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_dir (acc.wr_dir[r]),
            .wr_set (acc.wr_set[r]),
            .wr_clr (acc.wr_clr[r]),
            .wdata  (bus_wdata),
            .q      (regs[r])
        );
    end

    gpio_bank_rdata #(
        .WIDTH (PIN_W)
    ) u_rdata (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd     (bus_rd),
        .rd_sel (acc.rd_dir),
        .regs   (regs),
        .rdata  (bus_rdata)
    );

    // Drive the pad-side masks from the register bank.
    assign fn_en_o  = regs[IDX_FN];
    assign drv_en_o = regs[IDX_DRV];

endmodule

// File: rtl/gpio_ctrl_bank_chk.sv
// Module: gpio_ctrl_bank_chk
// Port-level protocol checker for gpio_ctrl_bank, attached with bind.
// Assumes the byte-address map of the bank.
module gpio_ctrl_bank_chk #(
    parameter int PIN_W  = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [PIN_W-1:0]  bus_wdata,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [PIN_W-1:0]  bus_rdata,
    input logic [PIN_W-1:0]  fn_en_o,
    input logic [PIN_W-1:0]  drv_en_o
);

    logic listed;
    logic alias_rd;

    // Classify the current address against the map.
    always_comb begin
        listed = (bus_addr == ADDR_W'('h00)) || (bus_addr == ADDR_W'('h04)) ||
                 (bus_addr == ADDR_W'('h08)) || (bus_addr == ADDR_W'('h0C)) ||
                 (bus_addr == ADDR_W'('h10)) || (bus_addr == ADDR_W'('h14));
        alias_rd = (bus_addr == ADDR_W'('h04)) || (bus_addr == ADDR_W'('h08)) ||
                   (bus_addr == ADDR_W'('h10)) || (bus_addr == ADDR_W'('h14));
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (fn_en_o == {PIN_W{1'b1}} && drv_en_o == '0 && bus_rdata == '0)); // R1

    AST_FN_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'('h00)) |=> fn_en_o == $past(bus_wdata)); // R2

    AST_FN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'('h04)) |=>
        fn_en_o == ($past(fn_en_o) | $past(bus_wdata))); // R3

    AST_FN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'('h08)) |=>
        fn_en_o == ($past(fn_en_o) & ~$past(bus_wdata))); // R4

    AST_DRV_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'('h0C)) |=> drv_en_o == $past(bus_wdata)); // R5

    AST_DRV_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'('h10)) |=>
        drv_en_o == ($past(drv_en_o) | $past(bus_wdata))); // R6

    AST_DRV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'('h14)) |=>
        drv_en_o == ($past(drv_en_o) & ~$past(bus_wdata))); // R6

    AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && alias_rd) |=> bus_rdata == '0); // R7

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == '0); // R8

    AST_UNLISTED_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr || !listed) |=> ($stable(fn_en_o) && $stable(drv_en_o))); // R9

    AST_UNLISTED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !listed) |=> bus_rdata == '0); // R9

endmodule

bind gpio_ctrl_bank gpio_ctrl_bank_chk #(
    .PIN_W  (PIN_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .fn_en_o   (fn_en_o),
    .drv_en_o  (drv_en_o)
);

// File: tb/gpio_ctrl_bank_test.sv
// Bench: sweeps the address space and walks single pins through the
// aliases, checking against an arithmetic model of the address map.
module gpio_ctrl_bank_test;

    localparam int PIN_W  = 32;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [PIN_W-1:0]  bus_wdata = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [PIN_W-1:0]  bus_rdata;
    logic [PIN_W-1:0]  fn_en_o;
    logic [PIN_W-1:0]  drv_en_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    logic [PIN_W-1:0] m_fn;
    logic [PIN_W-1:0] m_drv;

    gpio_ctrl_bank #(
        .PIN_W  (PIN_W),
        .ADDR_W (ADDR_W)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .fn_en_o   (fn_en_o),
        .drv_en_o  (drv_en_o)
    );

    // 250 MHz clock.
    always #2 clk = ~clk;

    // Watchdog: counts cycles and ends a hung run as a failure.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [PIN_W-1:0] act,
                         input logic [PIN_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // Requirement tag for a write to the given address.
    function automatic string wtag(input int a);
        case (a)
            'h00: return "R2";
            'h04: return "R3";
            'h08: return "R4";
            'h0C: return "R5";
            'h10, 'h14: return "R6";
            default: return "R9";
        endcase
    endfunction

    // Model update of the address map for a write.
    task automatic model_write(input int a, input logic [PIN_W-1:0] d);
        case (a)
            'h00: m_fn  = d;
            'h04: m_fn  = m_fn | d;
            'h08: m_fn  = m_fn & ~d;
            'h0C: m_drv = d;
            'h10: m_drv = m_drv | d;
            'h14: m_drv = m_drv & ~d;
            default: ;
        endcase
    endtask

    function automatic logic [PIN_W-1:0] model_read(input int a);
        case (a)
            'h00: return m_fn;
            'h0C: return m_drv;
            default: return '0;
        endcase
    endfunction

    function automatic string rtag(input int a);
        case (a)
            'h00, 'h0C, 'h04, 'h08, 'h10, 'h14: return "R7";
            default: return "R9";
        endcase
    endfunction

    // One-cycle write, then check both masks against the model.
    task automatic do_write(input int a, input logic [PIN_W-1:0] d);
        @(negedge clk);
        bus_addr  = ADDR_W'(a);
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        model_write(a, d);
        check({wtag(a), " fn_en_o"}, fn_en_o, m_fn);
        check({wtag(a), " drv_en_o"}, drv_en_o, m_drv);
    endtask

    // One-cycle read; data is checked in the next cycle.
    task automatic do_read(input int a);
        @(negedge clk);
        bus_addr = ADDR_W'(a);
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
        check({rtag(a), " read"}, bus_rdata, model_read(a));
    endtask

    initial begin
        m_fn  = '1;
        m_drv = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 fn_en_o reset", fn_en_o, '1);
        check("R1 drv_en_o reset", drv_en_o, '0);
        check("R1 rdata reset", bus_rdata, '0);
        rst_n = 1'b1;
        do_read('h00);
        do_read('h0C);

        // R2..R9: sweep every address with an address-dependent pattern
        for (int a = 0; a < 64; a++) begin
            logic [PIN_W-1:0] pat;
            pat = 32'hA5C3_0F96 ^ (PIN_W'(a) * 32'h0101_0101) ^ {PIN_W'(a), 4'h0};
            do_write(a, pat);
            do_read(a);
            do_read('h00);
            do_read('h0C);
        end

        // R3, R4: walk each pin through the function-enable aliases
        do_write('h00, 32'h3C3C_5A5A);
        for (int b = 0; b < PIN_W; b++) begin
            do_write('h04, PIN_W'(1) << b);
            do_write('h08, PIN_W'(1) << ((b + 7) % PIN_W));
        end
        // R5, R6: walk each pin through the driver-enable aliases
        do_write('h0C, 32'hC3C3_A5A5);
        for (int b = 0; b < PIN_W; b++) begin
            do_write('h10, PIN_W'(1) << b);
            do_write('h14, PIN_W'(1) << ((b + 11) % PIN_W));
        end

        // R8: read and write of the same register in one cycle returns the old value
        @(negedge clk);
        bus_addr  = ADDR_W'('h00);
        bus_wdata = 32'h1234_5678;
        bus_wr    = 1'b1;
        bus_rd    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_rd = 1'b0;
        check("R8 read before write", bus_rdata, m_fn);
        model_write('h00, 32'h1234_5678);
        check("R2 write with read", fn_en_o, m_fn);
        // R8: data returns to zero after the read cycle
        @(negedge clk);
        check("R8 idle rdata", bus_rdata, '0);

        // R1: reset again restores opposite defaults
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 fn_en_o re-reset", fn_en_o, '1);
        check("R1 drv_en_o re-reset", drv_en_o, '0);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule